// File: doc/BRIEF.md
# Stall and Bus-Request Cause Tracker

This block keeps two small cause masks for a cache controller. The stall mask holds the reasons why the upstream access path must hold off new requests. The request mask holds the reasons why the downstream port wants the memory bus. Each cause bit has its own set strobe and its own clear strobe. The allocation logic that watches the miss queue, the write buffer and the target slots drives these strobes. The block turns each mask into one summary output: a stall for the upstream side and a bus request for the downstream side.

The two masks act on edges. When the stall mask goes from empty to non-empty, a free-running cycle counter supplies a timestamp and the block counts one stall event for the cause that opened the stall. When the stall mask goes back to empty, the block adds the cycles since that timestamp to a per-cause stalled-cycle total. When the request mask goes from empty to non-empty, the block emits a one-cycle send-start pulse, unless a bus retry is still outstanding. All statistics counters saturate at their maximum and do not wrap.

Top module: `stall_req_tracker`

## Requirements
- R1: On each clock edge the stall mask becomes (mask AND NOT clear) OR set, so a set of a cause wins over a clear of that cause in the same cycle. Cause bits: 0 is no free miss entry, 1 is no free write-buffer entry, 2 is no free target slot.
- R2: `stall_o` is high exactly while at least one stall-mask bit is set.
- R3: When the stall mask is empty and one or more stall set strobes are high, the event counter of the lowest-indexed cause being set increases by one. The current cycle count is stored as the stall start.
- R4: When the stall mask is non-empty and the update leaves it empty, the stalled-cycle counter of the lowest-indexed cause in the mask before the update increases by the number of cycles the mask was non-empty.
- R5: The request mask follows the same update rule as R1, with set winning over clear. Cause bits: 0 is the miss queue, 1 is the write buffer, 2 is prefetch. A clear affects only its own bit.
- R6: `bus_req_o` is high exactly while at least one request-mask bit is set.
- R7: `send_start_o` is high for one cycle after an edge at which the request mask was empty, at least one request set strobe was high, and `retry_pend_i` was low.
- R8: No send-start pulse follows an edge at which `retry_pend_i` was high or the request mask was already non-empty.
- R9: Every statistics counter saturates at its all-ones value and never wraps.
- R10: Reset clears both masks, all counters and the send-start pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stall_set_i | input | N_STALL | Per-cause stall set strobes |
| stall_clr_i | input | N_STALL | Per-cause stall clear strobes |
| req_set_i | input | N_REQ | Per-cause bus-request set strobes |
| req_clr_i | input | N_REQ | Per-cause bus-request clear strobes |
| retry_pend_i | input | 1 | A bus retry is still outstanding |
| stall_mask_o | output | N_STALL | Current stall cause mask |
| stall_o | output | 1 | Upstream stall |
| req_mask_o | output | N_REQ | Current bus-request cause mask |
| bus_req_o | output | 1 | Downstream bus request |
| send_start_o | output | 1 | One-cycle pulse on the first bus request |
| stall_evt_cnt_o | output | N_STALL*CNT_W | Per-cause stall event counters, cause i at bits [i*CNT_W +: CNT_W] |
| stall_cyc_cnt_o | output | N_STALL*CNT_W | Per-cause stalled-cycle counters, same layout |

## Verification
The bench builds the block with three causes per mask, 4-bit statistics counters and a 16-bit timestamp. With 4-bit counters, both the event counters and the cycle totals reach saturation within a few thousand random cycles, so R9 is exercised on every cause. With short, overlapping stalls, both the lowest-index attribution on simultaneous sets and the elapsed-cycle credit on the final clear are exercised many times. Directed steps cover a set and a clear of the same cause in one cycle, and a first request made while a retry is pending.

// File: rtl/stall_req_tracker_pkg.sv
package stall_req_tracker_pkg;
  typedef enum logic [1:0] {
    STALL_NO_MISS_ENTRY = 2'd0,
    STALL_NO_WBUF_ENTRY = 2'd1,
    STALL_NO_TARGET     = 2'd2
  } stall_cause_e;

  typedef enum logic [1:0] {
    BREQ_MISS_Q  = 2'd0,
    BREQ_WBUF    = 2'd1,
    BREQ_PREFTCH = 2'd2
  } breq_cause_e;

  localparam int unsigned DEF_CNT_W = 32;
  localparam int unsigned DEF_TS_W  = 32;
endpackage

// File: rtl/srt_cause_mask.sv
module srt_cause_mask #(
  parameter int unsigned N  = 3,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  set_i,
  input  logic [N-1:0]  clr_i,
  output logic [N-1:0]  mask_o,
  output logic          open_o,
  output logic          close_o,
  output logic [IW-1:0] open_idx_o,
  output logic [IW-1:0] close_idx_o
);
  logic [N-1:0] mask_q, mask_d;

  always_comb begin
    mask_d  = (mask_q & ~clr_i) | set_i;
    open_o  = (mask_q == '0) && (set_i != '0);
    close_o = (mask_q != '0) && (mask_d == '0);
    open_idx_o  = '0;
    close_idx_o = '0;
    // descending scan so the lowest index is the last one written
    for (int i = N - 1; i >= 0; i--) begin
      if (set_i[i])  open_idx_o  = IW'(i);
      if (mask_q[i]) close_idx_o = IW'(i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/srt_sat_acc.sv
module srt_sat_acc #(
  parameter int unsigned W     = 32,
  parameter int unsigned INC_W = 1,
  localparam int unsigned SW   = ((W > INC_W) ? W : INC_W) + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [W-1:0]     cnt_o
);
  localparam logic [SW-1:0] MAX_V = SW'({W{1'b1}});

  logic [W-1:0]  cnt_q;
  logic [SW-1:0] sum;

  assign sum = SW'(cnt_q) + SW'(inc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (en_i)   cnt_q <= (sum > MAX_V) ? {W{1'b1}} : sum[W-1:0];
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/stall_req_tracker.sv
module stall_req_tracker
  import stall_req_tracker_pkg::*;
#(
  parameter int unsigned N_STALL = 3,
  parameter int unsigned N_REQ   = 3,
  parameter int unsigned CNT_W   = DEF_CNT_W,
  parameter int unsigned TS_W    = DEF_TS_W
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N_STALL-1:0]       stall_set_i,
  input  logic [N_STALL-1:0]       stall_clr_i,
  input  logic [N_REQ-1:0]         req_set_i,
  input  logic [N_REQ-1:0]         req_clr_i,
  input  logic                     retry_pend_i,
  output logic [N_STALL-1:0]       stall_mask_o,
  output logic                     stall_o,
  output logic [N_REQ-1:0]         req_mask_o,
  output logic                     bus_req_o,
  output logic                     send_start_o,
  output logic [N_STALL*CNT_W-1:0] stall_evt_cnt_o,
  output logic [N_STALL*CNT_W-1:0] stall_cyc_cnt_o
);
  localparam int unsigned SIW = (N_STALL > 1) ? $clog2(N_STALL) : 1;
  localparam int unsigned RIW = (N_REQ > 1) ? $clog2(N_REQ) : 1;

  logic [TS_W-1:0] cycle_q, start_q, elapsed;
  logic            s_open, s_close, r_open, r_close;
  logic [SIW-1:0]  s_open_idx, s_close_idx;
  logic [RIW-1:0]  r_open_idx, r_close_idx;
  logic            send_q;

  srt_cause_mask #(.N(N_STALL)) u_stall_mask (
    .clk_i, .rst_ni,
    .set_i(stall_set_i), .clr_i(stall_clr_i), .mask_o(stall_mask_o),
    .open_o(s_open), .close_o(s_close),
    .open_idx_o(s_open_idx), .close_idx_o(s_close_idx)
  );

  srt_cause_mask #(.N(N_REQ)) u_req_mask (
    .clk_i, .rst_ni,
    .set_i(req_set_i), .clr_i(req_clr_i), .mask_o(req_mask_o),
    .open_o(r_open), .close_o(r_close),
    .open_idx_o(r_open_idx), .close_idx_o(r_close_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cycle_q <= '0;
      start_q <= '0;
      send_q  <= 1'b0;
    end else begin
      cycle_q <= cycle_q + 1'b1;
      if (s_open) start_q <= cycle_q;
      send_q <= r_open && !retry_pend_i;
    end
  end

  assign elapsed = cycle_q - start_q;

  for (genvar g = 0; g < N_STALL; g++) begin : g_stat
    srt_sat_acc #(.W(CNT_W), .INC_W(1)) u_evt (
      .clk_i, .rst_ni,
      .en_i(s_open && (s_open_idx == SIW'(g))),
      .inc_i(1'b1),
      .cnt_o(stall_evt_cnt_o[g*CNT_W +: CNT_W])
    );
    srt_sat_acc #(.W(CNT_W), .INC_W(TS_W)) u_cyc (
      .clk_i, .rst_ni,
      .en_i(s_close && (s_close_idx == SIW'(g))),
      .inc_i(elapsed),
      .cnt_o(stall_cyc_cnt_o[g*CNT_W +: CNT_W])
    );
  end

  assign stall_o      = |stall_mask_o;
  assign bus_req_o    = |req_mask_o;
  assign send_start_o = send_q;

  logic unused_ok;
  assign unused_ok = ^{r_close, r_open_idx, r_close_idx};
endmodule

// File: rtl/stall_req_tracker_chk.sv
module stall_req_tracker_chk #(
  parameter int unsigned N_STALL = 3,
  parameter int unsigned N_REQ   = 3,
  parameter int unsigned CNT_W   = 32
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [N_STALL-1:0]       stall_set_i,
  input logic [N_STALL-1:0]       stall_clr_i,
  input logic [N_REQ-1:0]         req_set_i,
  input logic [N_REQ-1:0]         req_clr_i,
  input logic                     retry_pend_i,
  input logic [N_STALL-1:0]       stall_mask_o,
  input logic                     stall_o,
  input logic [N_REQ-1:0]         req_mask_o,
  input logic                     bus_req_o,
  input logic                     send_start_o,
  input logic [N_STALL*CNT_W-1:0] stall_evt_cnt_o,
  input logic [N_STALL*CNT_W-1:0] stall_cyc_cnt_o
);
  a_r1_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_set_i != '0) |=> ((stall_mask_o & $past(stall_set_i)) == $past(stall_set_i)));

  a_r1_clear_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stall_clr_i & ~stall_set_i) != '0)
      |=> ((stall_mask_o & $past(stall_clr_i & ~stall_set_i)) == '0));

  a_r2_stall_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o == (stall_mask_o != '0));

  a_r5_req_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_set_i != '0) |=> ((req_mask_o & $past(req_set_i)) == $past(req_set_i)));

  a_r6_bus_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o == (req_mask_o != '0));

  a_r7_send_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_mask_o == '0) && (req_set_i != '0) && !retry_pend_i) |=> send_start_o);

  a_r8_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (retry_pend_i || (req_mask_o != '0)) |=> !send_start_o);

  for (genvar g = 0; g < N_STALL; g++) begin : g_mono
    a_r9_evt_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_evt_cnt_o[g*CNT_W +: CNT_W] >= $past(stall_evt_cnt_o[g*CNT_W +: CNT_W]));
    a_r9_cyc_no_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stall_cyc_cnt_o[g*CNT_W +: CNT_W] >= $past(stall_cyc_cnt_o[g*CNT_W +: CNT_W]));
  end
endmodule

bind stall_req_tracker stall_req_tracker_chk #(
  .N_STALL(N_STALL), .N_REQ(N_REQ), .CNT_W(CNT_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .stall_set_i(stall_set_i), .stall_clr_i(stall_clr_i),
  .req_set_i(req_set_i), .req_clr_i(req_clr_i),
  .retry_pend_i(retry_pend_i),
  .stall_mask_o(stall_mask_o), .stall_o(stall_o),
  .req_mask_o(req_mask_o), .bus_req_o(bus_req_o),
  .send_start_o(send_start_o),
  .stall_evt_cnt_o(stall_evt_cnt_o), .stall_cyc_cnt_o(stall_cyc_cnt_o)
);

// File: tb/stall_req_tracker_tb.sv
module stall_req_tracker_tb;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NS = 3;
  localparam int NR = 3;
  localparam int CW = 4;
  localparam int TW = 16;
  localparam int SAT = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] ss = '0, sc = '0;
  logic [NR-1:0] rs = '0, rc = '0;
  logic          rt = 1'b0;
  logic [NS-1:0] smask;
  logic [NR-1:0] rmask;
  logic          stall, breq, pulse;
  logic [NS*CW-1:0] evt, cyc;

  int checks = 0, errors = 0;
  bit finished = 0;

  // reference state
  int m_smask = 0, m_rmask = 0, m_start = 0, m_cyc_now = 0;
  int m_pulse = 0;
  int m_evt[NS], m_stc[NS];

  always #10 clk = ~clk;

  stall_req_tracker #(.N_STALL(NS), .N_REQ(NR), .CNT_W(CW), .TS_W(TW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .stall_set_i(ss), .stall_clr_i(sc), .req_set_i(rs), .req_clr_i(rc),
    .retry_pend_i(rt),
    .stall_mask_o(smask), .stall_o(stall), .req_mask_o(rmask), .bus_req_o(breq),
    .send_start_o(pulse), .stall_evt_cnt_o(evt), .stall_cyc_cnt_o(cyc)
  );

  function automatic int lowest(input int v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  function automatic int sat_add(input int a, input int b);
    return (a + b > SAT) ? SAT : a + b;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(int'(smask) == m_smask, "R1", "stall mask", int'(smask), m_smask);
    chk(stall == (m_smask != 0), "R2", "stall_o", int'(stall), int'(m_smask != 0));
    chk(int'(rmask) == m_rmask, "R5", "req mask", int'(rmask), m_rmask);
    chk(breq == (m_rmask != 0), "R6", "bus_req_o", int'(breq), int'(m_rmask != 0));
    chk(int'(pulse) == m_pulse, "R7 R8", "send_start_o", int'(pulse), m_pulse);
    for (int i = 0; i < NS; i++) begin
      chk(int'(evt[i*CW +: CW]) == m_evt[i], "R3 R9", $sformatf("event cnt %0d", i),
          int'(evt[i*CW +: CW]), m_evt[i]);
      chk(int'(cyc[i*CW +: CW]) == m_stc[i], "R4 R9", $sformatf("cycle cnt %0d", i),
          int'(cyc[i*CW +: CW]), m_stc[i]);
    end
  endtask

  task automatic step(input int a_ss, input int a_sc, input int a_rs,
                      input int a_rc, input bit a_rt);
    int nm;
    @(negedge clk);
    ss = NS'(a_ss); sc = NS'(a_sc); rs = NR'(a_rs); rc = NR'(a_rc); rt = a_rt;
    @(posedge clk);
    nm = (m_smask & ~a_sc) | a_ss;
    if (m_smask == 0 && a_ss != 0) begin
      m_evt[lowest(a_ss)] = sat_add(m_evt[lowest(a_ss)], 1);
      m_start = m_cyc_now;
    end
    if (m_smask != 0 && nm == 0)
      m_stc[lowest(m_smask)] = sat_add(m_stc[lowest(m_smask)], m_cyc_now - m_start);
    m_smask = nm;
    m_pulse = (m_rmask == 0 && a_rs != 0 && !a_rt) ? 1 : 0;
    m_rmask = (m_rmask & ~a_rc) | a_rs;
    m_cyc_now++;
    #2;
    compare_all();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed = 32'h5eed_1234;
    void'($urandom(seed));
    for (int i = 0; i < NS; i++) begin m_evt[i] = 0; m_stc[i] = 0; end
    #35;
    // R10 reset state
    compare_all();
    chk(pulse == 1'b0, "R10", "pulse in reset", int'(pulse), 0);
    @(negedge clk); rst_n = 1'b1;

    // R1: set and clear of same cause together, set wins
    step(2, 2, 0, 0, 0);
    chk(smask == 3'b010, "R1", "set wins", int'(smask), 2);
    step(0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0);
    step(0, 2, 0, 0, 0);            // R4: 3 cycles credited to cause 1
    chk(int'(cyc[CW +: CW]) == 3, "R4", "elapsed credit", int'(cyc[CW +: CW]), 3);
    // R3: simultaneous open of causes 0 and 2, cause 0 gets the event
    step(5, 0, 0, 0, 0);
    chk(int'(evt[0 +: CW]) == 1, "R3", "lowest cause event", int'(evt[0 +: CW]), 1);
    step(0, 5, 0, 0, 0);
    // R8: first request while retry pending, no pulse
    step(0, 0, 1, 0, 1);
    chk(pulse == 1'b0, "R8", "retry blocks pulse", int'(pulse), 0);
    step(0, 0, 2, 0, 0);
    chk(pulse == 1'b0, "R8", "mask busy no pulse", int'(pulse), 0);
    // R5: clearing one cause keeps the other
    step(0, 1, 0, 1, 0);
    chk(rmask == 3'b010, "R5", "clear own bit only", int'(rmask), 2);
    step(0, 0, 0, 2, 0);
    // R7: first request with no retry
    step(0, 0, 4, 0, 0);
    chk(pulse == 1'b1, "R7", "send pulse", int'(pulse), 1);
    step(0, 0, 0, 0, 0);
    chk(pulse == 1'b0, "R7", "pulse one cycle", int'(pulse), 0);
    step(0, 0, 0, 4, 0);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      int a, b, c, d;
      a = 0; b = 0; c = 0; d = 0;
      for (int k = 0; k < 3; k++) begin
        if ($urandom_range(7) == 0) a |= (1 << k);
        if ($urandom_range(3) == 0) b |= (1 << k);
        if ($urandom_range(5) == 0) c |= (1 << k);
        if ($urandom_range(3) == 0) d |= (1 << k);
      end
      step(a, b, c, d, $urandom_range(3) == 0);
    end
    step(0, 7, 0, 7, 0);
    chk(int'(evt[0 +: CW]) == SAT, "R9", "event saturated", int'(evt[0 +: CW]), SAT);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule